// File: doc/BRIEF.md
# Banked GPIO Register File

This block is a GPIO logical device on a byte-wide configuration register bus. Its pins are grouped into banks of at most eight. Each bank has a group of four registers that starts at the bank's own base index. The four registers are pin direction, output latch, synchronized pin level and drive mode. Software writes a register by presenting an 8-bit index and data with a one-cycle write strobe. It reads by presenting an index and sampling the combinational read data in the same cycle.

Toward the pad ring, each pin gets an output value, an output enable and an open-drain indication. The pad ring returns the level on the pin, which passes through a two-flop synchronizer before it can be read. The number of banks, the pin count of each bank and each bank's base index are parameters. The default has four banks: 0xF0 with 6 pins, 0xE0 with 8, 0x80 with 5 and 0x88 with 7. This shows both the descending base spacing of 0x10 and an extra bank at 0x88 after the one at 0x80.

The block has no state machine. Each bank holds three register sets that are written under the strobe. The only sequential path is the synchronizer, which is a fixed two-stage pipeline of flops with no states or transitions.

Top module: `gpio_bank_regfile`

## Requirements
- R1: After reset every direction bit, output latch bit and drive mode bit is 0. All pins are inputs in open-drain mode, and no pad enable is asserted.
- R2: Within a bank, index base+0 is the direction register and a bit value of 1 makes that pin an output. Base+1 is the output latch, base+2 is the pin level and base+3 is the drive mode. Direction, latch and mode read back what was last written to them.
- R3: A pin is driven only while its direction bit is 1. When its mode bit is 1 (push-pull), it is enabled and pad_out equals its latch bit.
- R4: When a pin's mode bit is 0 (open-drain), it is enabled only while its latch bit is 0, with pad_out 0, and it is released otherwise. pad_od is 1 for an output pin in open-drain mode.
- R5: A change on pad_in appears at index base+2 after the second rising clock edge, and not after the first.
- R6: Writes to index base+2 have no effect on any register or pad output.
- R7: Bits at or above a bank's pin count read as 0, ignore writes and are never driven.
- R8: An index outside every bank's four-register group reads 0x00, and a write to it changes nothing.
- R9: Banks are independent. A write decodes to at most one bank and leaves every other bank unchanged.
- R10: A write takes effect at the rising edge that samples the strobe. A read of the same index in the strobe cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_index | input | 8 | Register index |
| cfg_wdata | input | 8 | Write data |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_rdata | output | 8 | Read data for cfg_index (combinational) |
| pad_in | input | 8*NUM_BANKS | Pin levels from pads, bank i at bits [8i+7:8i] |
| pad_out | output | 8*NUM_BANKS | Value driven on each pin |
| pad_oe | output | 8*NUM_BANKS | Drive enable for each pin |
| pad_od | output | 8*NUM_BANKS | Pin is an output in open-drain mode |

## Verification
A write strobe and a read of the same index can fall in the same cycle. The bench provokes this with directed writes that check read data before the edge, expecting the old value, and after it, expecting the new one. A pad input change can also fall in the same cycle as a write to the pin-level register. The bench drives both together and then checks three things: the register tracks only the synchronized pin after two edges, the write is ignored, and the pad outputs are unchanged.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [1:0] {
        OFS_DIR  = 2'd0,
        OFS_OUT  = 2'd1,
        OFS_PIN  = 2'd2,
        OFS_MODE = 2'd3
    } reg_ofs_e;

    localparam int unsigned BANK_W = 8;

    function automatic logic [BANK_W-1:0] pin_mask(input int unsigned n);
        logic [BANK_W-1:0] m;
        for (int unsigned k = 0; k < BANK_W; k++) begin
            m[k] = (k < n);
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter logic [7:0]  BASE = 8'hF0,
    parameter int unsigned PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_index,
    input  logic [7:0]        cfg_wdata,
    input  logic              cfg_wr,
    input  logic [BANK_W-1:0] pin_in,
    output logic              hit,
    output logic [7:0]        rd_data,
    output logic [BANK_W-1:0] pad_out,
    output logic [BANK_W-1:0] pad_oe,
    output logic [BANK_W-1:0] pad_od
);
    localparam logic [BANK_W-1:0] MASK = pin_mask(PINS);

    logic [BANK_W-1:0] dir_q, out_q, mode_q, pin_sync;
    reg_ofs_e          ofs;

    assign hit = (cfg_index[7:2] == BASE[7:2]);
    assign ofs = reg_ofs_e'(cfg_index[1:0]);

    gpio_sync2 #(.W(BANK_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            out_q  <= '0;
            mode_q <= '0;
        end else if (cfg_wr && hit) begin
            unique case (ofs)
                OFS_DIR:  dir_q  <= cfg_wdata & MASK;
                OFS_OUT:  out_q  <= cfg_wdata & MASK;
                OFS_MODE: mode_q <= cfg_wdata & MASK;
                OFS_PIN:  ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        if (hit) begin
            unique case (ofs)
                OFS_DIR:  rd_data = dir_q;
                OFS_OUT:  rd_data = out_q;
                OFS_PIN:  rd_data = pin_sync & MASK;
                OFS_MODE: rd_data = mode_q;
            endcase
        end
    end

    always_comb begin
        pad_oe  = dir_q & (mode_q | ~out_q);
        pad_out = out_q & mode_q;
        pad_od  = dir_q & ~mode_q;
    end

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && hit && ofs == OFS_DIR) |=> (dir_q == ($past(cfg_wdata) & MASK)));

    assert_pin_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && hit && ofs == OFS_PIN) |=> ($stable(dir_q) && $stable(out_q) && $stable(mode_q)));

    assert_unused_undriven_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~MASK) == '0));

    assert_od_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~mode_q & out_q) == '0));
endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
    import gpio_bank_pkg::*;
#(
    parameter int unsigned               NUM_BANKS = 4,
    parameter logic [NUM_BANKS*8-1:0]    BANK_BASE = {8'h88, 8'h80, 8'hE0, 8'hF0},
    parameter logic [NUM_BANKS*4-1:0]    BANK_PINS = {4'd7, 4'd5, 4'd8, 4'd6}
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [7:0]                    cfg_index,
    input  logic [7:0]                    cfg_wdata,
    input  logic                          cfg_wr,
    output logic [7:0]                    cfg_rdata,
    input  logic [NUM_BANKS*BANK_W-1:0]   pad_in,
    output logic [NUM_BANKS*BANK_W-1:0]   pad_out,
    output logic [NUM_BANKS*BANK_W-1:0]   pad_oe,
    output logic [NUM_BANKS*BANK_W-1:0]   pad_od
);
    logic [NUM_BANKS-1:0] hit_vec;
    logic [7:0]           bank_rd [NUM_BANKS];

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        gpio_bank #(
            .BASE (BANK_BASE[i*8 +: 8]),
            .PINS (int'(BANK_PINS[i*4 +: 4]))
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_index (cfg_index),
            .cfg_wdata (cfg_wdata),
            .cfg_wr    (cfg_wr),
            .pin_in    (pad_in[i*BANK_W +: BANK_W]),
            .hit       (hit_vec[i]),
            .rd_data   (bank_rd[i]),
            .pad_out   (pad_out[i*BANK_W +: BANK_W]),
            .pad_oe    (pad_oe[i*BANK_W +: BANK_W]),
            .pad_od    (pad_od[i*BANK_W +: BANK_W])
        );
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            cfg_rdata = cfg_rdata | bank_rd[i];
        end
    end

    assert_single_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_outside_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec == '0) |-> (cfg_rdata == 8'h00));
endmodule

// File: tb/sim_gpio_bank_regfile.sv
module sim_gpio_bank_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam logic [7:0] BASES [NB] = '{8'hF0, 8'hE0, 8'h80, 8'h88};
    localparam int         PINS  [NB] = '{6, 8, 5, 7};

    logic              clk = 0;
    logic              rst_n = 0;
    logic [7:0]        cfg_index = 0, cfg_wdata = 0;
    logic              cfg_wr = 0;
    logic [7:0]        cfg_rdata;
    logic [NB*8-1:0]   pad_in = 0, pad_out, pad_oe, pad_od;

    int checks = 0, errors = 0;
    logic [7:0] m_dir [NB], m_out [NB], m_mode [NB], m_pin [NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank_regfile u0 (
        .clk(clk), .rst_n(rst_n), .cfg_index(cfg_index), .cfg_wdata(cfg_wdata),
        .cfg_wr(cfg_wr), .cfg_rdata(cfg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od)
    );

    function automatic logic [7:0] mask_of(input int b);
        return 8'((1 << PINS[b]) - 1);
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] idx);
        for (int b = 0; b < NB; b++) begin
            if (idx[7:2] == BASES[b][7:2]) begin
                case (idx[1:0])
                    2'd0: return m_dir[b];
                    2'd1: return m_out[b];
                    2'd2: return m_pin[b] & mask_of(b);
                    default: return m_mode[b];
                endcase
            end
        end
        return 8'h00;
    endfunction

    function automatic logic [NB*8-1:0] exp_oe();
        logic [NB*8-1:0] v;
        for (int b = 0; b < NB; b++)
            v[b*8 +: 8] = m_dir[b] & (m_mode[b] | ~m_out[b]);
        return v;
    endfunction

    function automatic logic [NB*8-1:0] exp_out();
        logic [NB*8-1:0] v;
        for (int b = 0; b < NB; b++) v[b*8 +: 8] = m_out[b] & m_mode[b];
        return v;
    endfunction

    function automatic logic [NB*8-1:0] exp_od();
        logic [NB*8-1:0] v;
        for (int b = 0; b < NB; b++) v[b*8 +: 8] = m_dir[b] & ~m_mode[b];
        return v;
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%02h exp=%02h", req, act, exp);
        end
    endtask

    task automatic check_read(input string req, input logic [7:0] idx);
        cfg_index = idx;
        #1;
        check8(req, cfg_rdata, exp_read(idx));
    endtask

    task automatic check_pads(input string req);
        checks++;
        if (pad_oe !== exp_oe() || pad_out !== exp_out() || pad_od !== exp_od()) begin
            errors++;
            $display("FAIL %s oe/out/od act=%h/%h/%h exp=%h/%h/%h", req,
                     pad_oe, pad_out, pad_od, exp_oe(), exp_out(), exp_od());
        end
    endtask

    task automatic model_write(input logic [7:0] idx, input logic [7:0] d);
        for (int b = 0; b < NB; b++) begin
            if (idx[7:2] == BASES[b][7:2]) begin
                case (idx[1:0])
                    2'd0: m_dir[b]  = d & mask_of(b);
                    2'd1: m_out[b]  = d & mask_of(b);
                    2'd3: m_mode[b] = d & mask_of(b);
                    default: ;
                endcase
            end
        end
    endtask

    // Write with R10 check: read in strobe cycle shows old value.
    task automatic do_write(input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        cfg_index = idx; cfg_wdata = d; cfg_wr = 1;
        #1;
        check8("R10 old value in strobe cycle", cfg_rdata, exp_read(idx));
        @(negedge clk);
        cfg_wr = 0;
        model_write(idx, d);
        check_read("R10 new value after edge", idx);
    endtask

    task automatic set_pins(input logic [NB*8-1:0] v);
        @(negedge clk);
        pad_in = v;
        @(negedge clk);
        check_read("R5 not visible after one edge", 8'hF2);
        @(negedge clk);
        for (int b = 0; b < NB; b++) m_pin[b] = v[b*8 +: 8];
        check_read("R5 visible after two edges", 8'hF2);
        check_read("R5 pin level bank E0", 8'hE2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        for (int b = 0; b < NB; b++) begin
            m_dir[b] = 0; m_out[b] = 0; m_mode[b] = 0; m_pin[b] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        for (int b = 0; b < NB; b++) begin
            check_read("R1 reset dir", BASES[b]);
            check_read("R1 reset out", BASES[b] + 8'd1);
            check_read("R1 reset mode", BASES[b] + 8'd3);
        end
        check_pads("R1 reset pads");

        // R2/R3 push-pull output
        do_write(8'hE0, 8'hFF);
        do_write(8'hE3, 8'hF0);
        do_write(8'hE1, 8'hA5);
        check_pads("R3 push-pull drive");
        // R4 open-drain: low 4 pins of E0 bank are open-drain
        check_read("R4 mode readback", 8'hE3);
        check_pads("R4 open-drain drive");
        // R7 unused bits on 5-pin bank at 0x80
        do_write(8'h80, 8'hFF);
        check_read("R7 upper bits read 0", 8'h80);
        do_write(8'h83, 8'hFF);
        do_write(8'h81, 8'hFF);
        check_pads("R7 unused pins undriven");
        // R9 extra bank at 0x88 independent of 0x80
        do_write(8'h88, 8'h7F);
        check_read("R9 bank 80 unchanged", 8'h80);
        check_read("R9 bank 88 dir", 8'h88);
        // R8 outside indexes
        do_write(8'h84, 8'hFF);
        do_write(8'h00, 8'h5A);
        check_read("R8 outside reads zero", 8'h84);
        check_read("R8 outside reads zero", 8'hFF);
        check_pads("R8 outside write no effect");
        // R5 synchronizer
        set_pins({8'h3C, 8'hFF, 8'h5A, 8'hFF});
        check_read("R7 pin level masked 0xF0 bank", 8'hF2);
        // R6 write to pin register together with pin change
        @(negedge clk);
        pad_in = {8'h11, 8'h22, 8'h33, 8'h0F};
        cfg_index = 8'hF2; cfg_wdata = 8'hFF; cfg_wr = 1;
        @(negedge clk);
        cfg_wr = 0;
        @(negedge clk);
        for (int b = 0; b < NB; b++) m_pin[b] = pad_in[b*8 +: 8];
        check_read("R6 pin write ignored", 8'hF2);
        check_read("R6 dir untouched", 8'hF0);
        check_pads("R6 pads untouched");

        // Random phase
        for (int it = 0; it < 400; it++) begin
            int b;
            logic [7:0] idx;
            b = int'($urandom % NB);
            idx = ($urandom % 8 == 0) ? 8'($urandom) : (BASES[b] + 8'($urandom % 4));
            if ($urandom % 6 == 0) begin
                set_pins(NB*8'($urandom) | {$urandom, $urandom});
            end else begin
                do_write(idx, 8'($urandom));
                check_pads("R3 R4 random pads");
                check_read("R2 random readback", BASES[int'($urandom % NB)] + 8'($urandom % 4));
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule